// File: doc/BRIEF.md
# Command Ring Buffer Fetcher

This block sits at the front of a command engine. It pulls 32-bit command words out of a circular buffer in local memory. Software sets up four things through a small register write port: the ring's base address in local memory, the ring length in bytes, the consumer position (head) and the producer position (tail). Both positions are byte offsets into the ring. Software adds commands after the tail and then moves the tail forward. While the ring is enabled and not empty, the fetcher reads the word at base plus head through a one-cycle memory read port. It hands each non-zero word to a downstream consumer over a valid/ready handshake.

An all-zero word is a padding no-op. The tail may only sit on an 8-byte boundary, so software pads a batch with no-ops whenever it holds an odd number of words. The fetcher drops these words without delivering them and counts them in a readable no-op counter, which software polls to confirm progress. Decoding of any other command is left to the consumer.

Top module: `cmd_ring_fetcher`

## Requirements
- R1: After reset, cmd_valid and mem_req are low, and the enable bit (CTRL bit 0), head, tail, no-op count and error flag (STAT bit 0) all read zero. Select codes: 0 CTRL, 1 BASE, 2 LEN, 3 HEAD, 4 TAIL, 5 NOPS (read only), 6 STAT (read only).
- R2: No memory read is issued while the ring is disabled or while head equals tail.
- R3: Every non-zero word between head and tail reaches cmd_data exactly once, in ring order, with its value unchanged.
- R4: Head and tail hold byte offsets. Head grows by 4 for each word consumed, whether the word is a command or a no-op, and tail reads back the last value accepted.
- R5: When head reaches the programmed length, it wraps to zero.
- R6: A word of value zero is never presented on cmd_data. Each such word adds one to the NOPS register.
- R7: A TAIL write whose bits [2:0] are not all zero is ignored, and it sets the error flag (STAT bit 0). The flag stays set until reset.
- R8: Each read addresses base plus head. At most one read is outstanding, so mem_req is never high in two consecutive cycles, and read data is taken one cycle after the request.
- R9: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_data holds its value.
- R10: Writes to BASE, LEN and HEAD are ignored while the ring is enabled. They take effect when the ring is disabled and the fetcher is idle. BASE is rounded down to a 4-byte boundary, HEAD to a 4-byte boundary and LEN to an 8-byte boundary.
- R11: A tail write is accepted while fetching is in progress. Whenever the tail moves past the head, fetching continues without any other action from software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select for writes |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_sel | input | 3 | Register select for reads |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the word to read |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_req |
| cmd_valid | output | 1 | A command word is presented |
| cmd_ready | input | 1 | Consumer accepts the presented word |
| cmd_data | output | 32 | Command word |

## Verification
Two events can land in the same clock cycle: a software tail update, and the head advancing when a command is accepted or a no-op is dropped. The bench provokes this by writing a new tail in the middle of a stream while the consumer applies pseudo-random backpressure. It does this once on a ring that wraps. The result is judged three ways: the scoreboard must see every queued word in order, the head must settle exactly on the new tail, and the no-op count must match the number of padding words written.

// File: rtl/ring_pkg.sv
package ring_pkg;
   localparam int CMD_W    = 32;
   localparam int DW_BYTES = 4;

   typedef enum logic [2:0] {
      RSEL_CTRL = 3'd0,
      RSEL_BASE = 3'd1,
      RSEL_LEN  = 3'd2,
      RSEL_HEAD = 3'd3,
      RSEL_TAIL = 3'd4,
      RSEL_NOPS = 3'd5,
      RSEL_STAT = 3'd6
   } rsel_e;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_WAIT = 2'd1,
      FS_HOLD = 2'd2
   } fstate_e;
endpackage

// File: rtl/ring_regs.sv
module ring_regs
   import ring_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int OFF_W   = 12,
   parameter int CNT_W   = 16,
   parameter bit CNT_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [CMD_W-1:0]  wr_data,
   input  logic [2:0]        rd_sel,
   output logic [CMD_W-1:0]  rd_data,
   input  logic              fetch_idle,
   input  logic              noop_pulse,
   input  logic [OFF_W-1:0]  head,
   output logic              enable,
   output logic [ADDR_W-1:0] base,
   output logic [OFF_W-1:0]  ring_len,
   output logic [OFF_W-1:0]  tail,
   output logic              head_load,
   output logic [OFF_W-1:0]  head_load_val,
   output logic              err
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             cfg_open;
   logic             tail_bad;
   logic [CNT_W-1:0] nop_cnt;
   logic             unused_wr;

   assign unused_wr     = ^wr_data;
   assign cfg_open      = !enable && fetch_idle;
   assign tail_bad      = wr_data[2:0] != 3'b000;
   assign head_load     = wr_en && (wr_sel == RSEL_HEAD) && cfg_open;
   assign head_load_val = {wr_data[OFF_W-1:2], 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable   <= 1'b0;
         base     <= '0;
         ring_len <= '0;
         tail     <= '0;
         err      <= 1'b0;
      end else if (wr_en) begin
         case (wr_sel)
            RSEL_CTRL: enable <= wr_data[0];
            RSEL_BASE: if (cfg_open) base <= {wr_data[ADDR_W-1:2], 2'b00};
            RSEL_LEN:  if (cfg_open) ring_len <= {wr_data[OFF_W-1:3], 3'b000};
            RSEL_TAIL: begin
               if (tail_bad) err  <= 1'b1;
               else          tail <= wr_data[OFF_W-1:0];
            end
            default: ;
         endcase
      end
   end

   generate
      if (CNT_SAT) begin : g_cnt_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               nop_cnt <= '0;
            else if (noop_pulse && nop_cnt != CNT_MAX)
               nop_cnt <= nop_cnt + 1'b1;
         end
      end else begin : g_cnt_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               nop_cnt <= '0;
            else if (noop_pulse)
               nop_cnt <= nop_cnt + 1'b1;
         end
      end
   endgenerate

   always_comb begin
      case (rd_sel)
         RSEL_CTRL: rd_data = {{(CMD_W-1){1'b0}}, enable};
         RSEL_BASE: rd_data = CMD_W'(base);
         RSEL_LEN:  rd_data = CMD_W'(ring_len);
         RSEL_HEAD: rd_data = CMD_W'(head);
         RSEL_TAIL: rd_data = CMD_W'(tail);
         RSEL_NOPS: rd_data = CMD_W'(nop_cnt);
         RSEL_STAT: rd_data = {{(CMD_W-1){1'b0}}, err};
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/ring_fetch_ctl.sv
module ring_fetch_ctl
   import ring_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  ring_len,
   input  logic [OFF_W-1:0]  tail,
   input  logic              head_load,
   input  logic [OFF_W-1:0]  head_load_val,
   input  logic [CMD_W-1:0]  mem_rdata,
   input  logic              cmd_taken,
   output logic [OFF_W-1:0]  head,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              load_cmd,
   output logic              noop_pulse,
   output logic              idle
);
   fstate_e          state, state_nx;
   logic             ring_empty;
   logic             word_zero;
   logic             advance;
   logic [OFF_W-1:0] head_inc;
   logic [OFF_W-1:0] head_step;

   assign ring_empty = head == tail;
   assign word_zero  = mem_rdata == '0;
   assign head_inc   = head + OFF_W'(DW_BYTES);
   assign head_step  = (head_inc == ring_len) ? '0 : head_inc;

   assign idle       = state == FS_IDLE;
   assign mem_req    = idle && enable && !ring_empty;
   assign mem_addr   = base + ADDR_W'(head);
   assign noop_pulse = (state == FS_WAIT) && word_zero;
   assign load_cmd   = (state == FS_WAIT) && !word_zero;
   assign advance    = noop_pulse || ((state == FS_HOLD) && cmd_taken);

   always_comb begin
      state_nx = state;
      case (state)
         FS_IDLE: if (mem_req) state_nx = FS_WAIT;
         FS_WAIT: state_nx = word_zero ? FS_IDLE : FS_HOLD;
         FS_HOLD: if (cmd_taken) state_nx = FS_IDLE;
         default: state_nx = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= FS_IDLE;
      else        state <= state_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         head <= '0;
      else if (head_load) head <= head_load_val;
      else if (advance)   head <= head_step;
   end
endmodule

// File: rtl/ring_out_stage.sv
module ring_out_stage #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         ready,
   output logic         valid,
   output logic [W-1:0] data,
   output logic         taken
);
   assign taken = valid && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         data  <= load_data;
      end else if (taken) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/cmd_ring_fetcher.sv
module cmd_ring_fetcher
   import ring_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int OFF_W       = 12,
   parameter int NOP_CNT_W   = 16,
   parameter bit NOP_CNT_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [2:0]        reg_wr_sel,
   input  logic [31:0]       reg_wr_data,
   input  logic [2:0]        reg_rd_sel,
   output logic [31:0]       reg_rd_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [31:0]       mem_rdata,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [31:0]       cmd_data
);
   generate
      if (ADDR_W > 32 || OFF_W > ADDR_W || OFF_W < 4) begin : g_bad_width
         $error("cmd_ring_fetcher: need 4 <= OFF_W <= ADDR_W <= 32");
      end
      if (NOP_CNT_W < 1 || NOP_CNT_W > 32) begin : g_bad_cnt
         $error("cmd_ring_fetcher: NOP_CNT_W must be 1..32");
      end
   endgenerate

   logic              ring_en;
   logic [ADDR_W-1:0] base_q;
   logic [OFF_W-1:0]  len_q;
   logic [OFF_W-1:0]  tail_q;
   logic [OFF_W-1:0]  head_q;
   logic              head_load;
   logic [OFF_W-1:0]  head_load_val;
   logic              err_q;
   logic              fetch_idle;
   logic              noop_pulse;
   logic              load_cmd;
   logic              cmd_taken;

   ring_regs #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .CNT_W  (NOP_CNT_W),
      .CNT_SAT(NOP_CNT_SAT)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (reg_wr_en),
      .wr_sel       (reg_wr_sel),
      .wr_data      (reg_wr_data),
      .rd_sel       (reg_rd_sel),
      .rd_data      (reg_rd_data),
      .fetch_idle   (fetch_idle),
      .noop_pulse   (noop_pulse),
      .head         (head_q),
      .enable       (ring_en),
      .base         (base_q),
      .ring_len     (len_q),
      .tail         (tail_q),
      .head_load    (head_load),
      .head_load_val(head_load_val),
      .err          (err_q)
   );

   ring_fetch_ctl #(
      .ADDR_W(ADDR_W),
      .OFF_W (OFF_W)
   ) u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (ring_en),
      .base         (base_q),
      .ring_len     (len_q),
      .tail         (tail_q),
      .head_load    (head_load),
      .head_load_val(head_load_val),
      .mem_rdata    (mem_rdata),
      .cmd_taken    (cmd_taken),
      .head         (head_q),
      .mem_req      (mem_req),
      .mem_addr     (mem_addr),
      .load_cmd     (load_cmd),
      .noop_pulse   (noop_pulse),
      .idle         (fetch_idle)
   );

   ring_out_stage #(
      .W(CMD_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_cmd),
      .load_data(mem_rdata),
      .ready    (cmd_ready),
      .valid    (cmd_valid),
      .data     (cmd_data),
      .taken    (cmd_taken)
   );
endmodule

// File: rtl/ring_fetch_chk.sv
module ring_fetch_chk #(
   parameter int OFF_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mem_req,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [31:0]      cmd_data,
   input logic [OFF_W-1:0] head,
   input logic [OFF_W-1:0] tail,
   input logic             err
);
   // R8: one read in flight, so no request on the next cycle
   assert_one_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R8: no new read while a command is still held
   assert_no_read_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !mem_req);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

   assert_no_zero_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_data != 32'd0));

   assert_tail_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tail[2:0] == 3'b000);

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   assert_head_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> (head != $past(head)));
endmodule

bind cmd_ring_fetcher ring_fetch_chk #(.OFF_W(OFF_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_req  (mem_req),
   .cmd_valid(cmd_valid),
   .cmd_ready(cmd_ready),
   .cmd_data (cmd_data),
   .head     (head_q),
   .tail     (tail_q),
   .err      (err_q)
);

// File: tb/sim_cmd_ring_fetcher.sv
module sim_cmd_ring_fetcher;
   localparam int ADDR_W = 16;
   localparam logic [2:0] S_CTRL = 3'd0, S_BASE = 3'd1, S_LEN = 3'd2,
                          S_HEAD = 3'd3, S_TAIL = 3'd4, S_NOPS = 3'd5, S_STAT = 3'd6;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              reg_wr_en;
   logic [2:0]        reg_wr_sel;
   logic [31:0]       reg_wr_data;
   logic [2:0]        reg_rd_sel;
   logic [31:0]       reg_rd_data;
   logic              mem_req;
   logic [ADDR_W-1:0] mem_addr;
   logic [31:0]       mem_rdata;
   logic              cmd_valid;
   logic              cmd_ready;
   logic [31:0]       cmd_data;

   always #10 clk = ~clk;

   cmd_ring_fetcher u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
      .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int req_cnt  = 0;
   logic [31:0] mem [0:127];
   logic [31:0] exp_q [$];
   int  ring_base, ring_len, sw_tail, exp_nops;
   logic prev_req;
   logic bp_on;
   logic [7:0] lfsr;
   logic hold_seen;
   logic [31:0] hold_data;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model: one-cycle read latency
   always @(posedge clk) begin
      if (mem_req) mem_rdata <= mem[mem_addr[8:2]];
   end

   // request watcher (R2 counting, R8 back-to-back)
   always @(posedge clk) begin
      if (!rst_n) prev_req <= 1'b0;
      else begin
         if (mem_req) begin
            req_cnt++;
            chk(!prev_req, "R8 back-to-back read", {31'd0, prev_req}, 32'd0);
         end
         prev_req <= mem_req;
      end
   end

   // consumer ready pattern
   always @(posedge clk) begin
      if (!rst_n) begin
         lfsr      <= 8'hA5;
         cmd_ready <= 1'b1;
      end else begin
         lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         cmd_ready <= bp_on ? lfsr[0] : 1'b1;
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_seen)
            chk(cmd_valid && cmd_data == hold_data, "R9 held word", cmd_data, hold_data);
         hold_seen = cmd_valid && !cmd_ready;
         hold_data = cmd_data;
         if (cmd_valid && cmd_ready) begin
            if (exp_q.size() == 0)
               chk(1'b0, "R3 unexpected word", cmd_data, 32'd0);
            else
               chk(cmd_data == exp_q[0], "R3 order/value", cmd_data, exp_q[0]);
            if (exp_q.size() != 0) void'(exp_q.pop_front());
         end
      end else begin
         hold_seen = 1'b0;
      end
   end

   task automatic reg_wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] sel, output logic [31:0] v);
      @(negedge clk);
      reg_rd_sel = sel;
      #1 v = reg_rd_data;
   endtask

   task automatic put_dw(input logic [31:0] v);
      mem[((ring_base + sw_tail) >> 2) & 127] = v;
      if (v != 0) exp_q.push_back(v);
      else        exp_nops++;
      sw_tail = (sw_tail + 4) % ring_len;
   endtask

   task automatic commit();
      reg_wr(S_TAIL, sw_tail);
   endtask

   task automatic drain();
      logic [31:0] h;
      for (int i = 0; i < 3000; i++) begin
         reg_rd(S_HEAD, h);
         if (h == sw_tail && exp_q.size() == 0 && !cmd_valid) break;
      end
      chk(exp_q.size() == 0, "R3 all delivered", exp_q.size(), 32'd0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      for (int i = 0; i < 128; i++) mem[i] = 32'hDEAD0000 | i;
      rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_sel = '0; reg_wr_data = '0;
      reg_rd_sel = '0; bp_on = 1'b0; mem_rdata = '0; exp_nops = 0;
      hold_seen = 1'b0; hold_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      chk(!cmd_valid, "R1 cmd_valid", {31'd0, cmd_valid}, 32'd0);
      chk(!mem_req, "R1 mem_req", {31'd0, mem_req}, 32'd0);
      reg_rd(S_CTRL, v); chk(v == 0, "R1 enable", v, 0);
      reg_rd(S_HEAD, v); chk(v == 0, "R1 head", v, 0);
      reg_rd(S_TAIL, v); chk(v == 0, "R1 tail", v, 0);
      reg_rd(S_NOPS, v); chk(v == 0, "R1 nops", v, 0);
      reg_rd(S_STAT, v); chk(v == 0, "R1 err", v, 0);

      // configure and enable an empty ring (R2)
      ring_base = 'h40; ring_len = 64; sw_tail = 0;
      reg_wr(S_BASE, ring_base);
      reg_wr(S_LEN, ring_len);
      reg_wr(S_CTRL, 1);
      req_cnt = 0;
      repeat (20) @(negedge clk);
      chk(req_cnt == 0, "R2 no read when empty", req_cnt, 0);

      // batch A: four commands
      for (int i = 0; i < 4; i++) put_dw(32'hA0000001 + i);
      commit();
      drain();
      reg_rd(S_HEAD, v); chk(v == 16, "R4 head bytes", v, 16);
      reg_rd(S_TAIL, v); chk(v == 16, "R4 tail readback", v, 16);

      // batch B: three commands padded with a no-op
      for (int i = 0; i < 3; i++) put_dw(32'hB0000010 + i);
      put_dw(32'h0);
      commit();
      drain();
      reg_rd(S_NOPS, v); chk(v == exp_nops, "R6 nop count", v, exp_nops);

      // misaligned tail write (R7)
      reg_wr(S_TAIL, 36);
      reg_rd(S_TAIL, v); chk(v == 32, "R7 tail unchanged", v, 32);
      reg_rd(S_STAT, v); chk(v[0] == 1'b1, "R7 err set", v, 1);
      req_cnt = 0;
      repeat (10) @(negedge clk);
      chk(req_cnt == 0, "R7 no fetch after bad tail", req_cnt, 0);

      // wrapping stream with backpressure, tail moved mid-stream (R5, R11)
      bp_on = 1'b1;
      put_dw(32'hC0000001); put_dw(32'h0); put_dw(32'hC0000003);
      put_dw(32'hC0000004); put_dw(32'hC0000005); put_dw(32'hC0000006);
      commit();
      repeat (3) @(negedge clk);
      put_dw(32'hC0000007); put_dw(32'hC0000008);
      put_dw(32'hC0000009); put_dw(32'h0);
      commit();
      drain();
      reg_rd(S_HEAD, v); chk(v == 8, "R5 head wrapped", v, 8);
      reg_rd(S_NOPS, v); chk(v == exp_nops, "R6 nop count after wrap", v, exp_nops);
      reg_rd(S_STAT, v); chk(v[0] == 1'b1, "R7 err sticky", v, 1);

      // config writes ignored while enabled (R10)
      reg_wr(S_HEAD, 0);
      reg_rd(S_HEAD, v); chk(v == 8, "R10 head locked", v, 8);
      reg_wr(S_LEN, 32);
      reg_rd(S_LEN, v); chk(v == 64, "R10 len locked", v, 64);
      reg_wr(S_BASE, 'h100);
      reg_rd(S_BASE, v); chk(v == 'h40, "R10 base locked", v, 'h40);

      // reprogram while disabled, new ring location (R10, R8 addressing)
      reg_wr(S_CTRL, 0);
      ring_base = 'h100; ring_len = 32; sw_tail = 0;
      reg_wr(S_BASE, ring_base);
      reg_wr(S_LEN, ring_len);
      reg_wr(S_HEAD, 0);
      reg_wr(S_TAIL, 0);
      reg_rd(S_BASE, v); chk(v == 'h100, "R10 base accepted", v, 'h100);
      reg_rd(S_HEAD, v); chk(v == 0, "R10 head accepted", v, 0);
      reg_wr(S_CTRL, 1);
      for (int i = 0; i < 6; i++) put_dw(32'hD0000020 + i);
      commit();
      drain();
      for (int i = 0; i < 4; i++) put_dw(32'hE0000030 + i);
      commit();
      drain();
      reg_rd(S_HEAD, v); chk(v == 8, "R5 head wrapped small ring", v, 8);
      chk(!cmd_valid, "R11 idle at end", {31'd0, cmd_valid}, 0);

      summary();
      $finish;
   end
endmodule